// File: doc/BRIEF.md
# Instruction Fetch Security Monitor

This block sits on the read-data path between memory and the CPU. For every bus access it decides whether the access breaks a security rule. When it does, the block replaces the returned word with all zeros in the same cycle. The CPU decodes an all-zero word as an illegal instruction and traps. Some rules always apply: no instruction fetch from firmware RAM, and no access of any kind to the part of the RAM region that has no physical RAM behind it. A mode-dependent rule forbids fetches from ROM in application mode, except when execution enters ROM through one of two entry pointers. These are the syscall pointer and the hash pointer.

An application can also set up one no-execute window with a small register interface. It writes the first and last addresses and then sets the enable. From that point the window and the enable are frozen until reset. The block also watches the CPU trap signal. Once a trap has been seen, the block blinks a red status LED output until reset.

Top module: `fetch_guard`

## Requirements
- R1: An instruction fetch (`bus_valid` and `bus_instr` high) whose address lies in the firmware RAM range returns zero in every mode. A data read at the same address returns `mem_rdata` unchanged.
- R2: Any access, fetch or data, whose offset into the RAM region is at or above `RAM_BYTES` returns zero. The last physical word passes.
- R3: In firmware mode (`app_mode` = 0), ROM fetches pass. In application mode, a ROM fetch returns zero unless ROM has been opened for execution. Data reads of ROM pass in both modes.
- R4: In application mode, a fetch at exactly `syscall_ptr` or `hash_ptr` inside ROM passes and opens ROM for execution. ROM stays open until the first fetch from outside ROM, which closes it again.
- R5: While the window is enabled, a fetch at an address in the inclusive range from first to last returns zero. Addresses one word outside either end pass, data reads inside the window pass, and nothing is blocked before the window is enabled.
- R6: Register word offsets are 0x60 for control, 0x61 for the first address and 0x62 for the last address. Control bit 0 is the enable. Writing 1 to it sets the enable, and it stays set until reset whatever is written later. Reads return the register values, with the enable in bit 0 of control.
- R7: After the enable is set, writes to the first and last registers are ignored.
- R8: Every access that breaks no rule returns `mem_rdata` unchanged, and a violating access returns zero in the same cycle. With `bus_valid` low the data passes unchanged.
- R9: When the CPU trap input is sampled high, the LED turns on in the next cycle. From then on it toggles every 2^(BLINK_BITS-1) cycles until reset, whatever the trap input does afterwards.
- R10: After reset the window registers and the enable read zero, ROM is closed for execution and the LED is off.

Top module ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe |
| bus_instr | input | 1 | Access is an instruction fetch |
| bus_addr | input | AW | Byte address of the access |
| mem_rdata | input | DW | Word returned by memory |
| cpu_rdata | output | DW | Word passed on to the CPU |
| app_mode | input | 1 | 1 = application mode, 0 = firmware mode |
| syscall_ptr | input | AW | Syscall entry address in ROM |
| hash_ptr | input | AW | Hash entry address in ROM |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word offset |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data |
| cpu_trap | input | 1 | CPU trap indication |
| led_red | output | 1 | Red status LED |

## Verification
The bench drives each rule with fetches and data reads at the same addresses. This shows that only the access kind decides the outcome. ROM is fetched in both modes, at the entry pointers, after them, and after a fetch out of ROM. This separates the mode rule from the entry state. The window is probed at both inclusive edges and one word beyond each, once before and once after enabling. Rewrites and clears after enabling show that the lock holds. The LED pattern is followed across more than one full blink period after a single trap pulse.

// File: rtl/fetch_guard.sv
module fetch_guard #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter logic [AW-1:0] ROM_BASE    = 32'h0000_0000,
  parameter logic [AW-1:0] ROM_BYTES   = 32'h0000_2000,
  parameter logic [AW-1:0] FWRAM_BASE  = 32'hD000_0000,
  parameter logic [AW-1:0] FWRAM_BYTES = 32'h0000_0800,
  parameter logic [AW-1:0] RAM_BASE    = 32'h4000_0000,
  parameter logic [AW-1:0] RAM_SPAN    = 32'h2000_0000,
  parameter logic [AW-1:0] RAM_BYTES   = 32'h0002_0000,
  parameter int BLINK_BITS = 23
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          bus_instr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          app_mode,
  input  logic [AW-1:0] syscall_ptr,
  input  logic [AW-1:0] hash_ptr,
  input  logic          reg_we,
  input  logic [7:0]    reg_addr,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          cpu_trap,
  output logic          led_red
);
  localparam logic [7:0] OFS_CTRL  = 8'h60;
  localparam logic [7:0] OFS_FIRST = 8'h61;
  localparam logic [7:0] OFS_LAST  = 8'h62;

  logic          win_en, rom_open, trap_seen;
  logic [AW-1:0] win_first, win_last;
  logic [BLINK_BITS-1:0] blink_cnt;

  logic [AW-1:0] rom_off, fw_off, ram_off;
  assign rom_off = bus_addr - ROM_BASE;
  assign fw_off  = bus_addr - FWRAM_BASE;
  assign ram_off = bus_addr - RAM_BASE;

  logic in_rom, in_fw, in_ram_gap, fetch, at_entry, in_win, viol;
  assign in_rom     = rom_off < ROM_BYTES;
  assign in_fw      = fw_off < FWRAM_BYTES;
  assign in_ram_gap = (ram_off < RAM_SPAN) && (ram_off >= RAM_BYTES);
  assign fetch      = bus_valid && bus_instr;
  assign at_entry   = in_rom && (bus_addr == syscall_ptr || bus_addr == hash_ptr);
  assign in_win     = win_en && bus_addr >= win_first && bus_addr <= win_last;

  assign viol = (bus_valid && in_ram_gap)
              || (fetch && in_fw)
              || (fetch && in_rom && app_mode && !rom_open && !at_entry)
              || (fetch && in_win);

  assign cpu_rdata = viol ? '0 : mem_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) rom_open <= 1'b0;
    else if (fetch) begin
      if (!in_rom) rom_open <= 1'b0;
      else if (at_entry) rom_open <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_en    <= 1'b0;
      win_first <= '0;
      win_last  <= '0;
    end else if (reg_we) begin
      if (reg_addr == OFS_CTRL && reg_wdata[0]) win_en <= 1'b1;
      if (reg_addr == OFS_FIRST && !win_en) win_first <= reg_wdata;
      if (reg_addr == OFS_LAST && !win_en) win_last <= reg_wdata;
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_CTRL:  reg_rdata = {{(AW-1){1'b0}}, win_en};
      OFS_FIRST: reg_rdata = win_first;
      OFS_LAST:  reg_rdata = win_last;
      default:   reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_seen <= 1'b0;
      blink_cnt <= '0;
    end else begin
      if (cpu_trap) trap_seen <= 1'b1;
      if (trap_seen) blink_cnt <= blink_cnt + 1'b1;
    end
  end

  assign led_red = trap_seen && !blink_cnt[BLINK_BITS-1];
endmodule

// File: rtl/fetch_guard_chk.sv
module fetch_guard_chk #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter logic [AW-1:0] FWRAM_BASE  = 32'hD000_0000,
  parameter logic [AW-1:0] FWRAM_BYTES = 32'h0000_0800
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_valid,
  input logic          bus_instr,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] mem_rdata,
  input logic [DW-1:0] cpu_rdata,
  input logic          win_en,
  input logic [AW-1:0] win_first,
  input logic [AW-1:0] win_last,
  input logic          trap_seen,
  input logic          led_red
);
  logic [AW-1:0] fw_off;
  assign fw_off = bus_addr - FWRAM_BASE;

  // R1
  fwram_fetch_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_instr && fw_off < FWRAM_BYTES) |-> cpu_rdata == '0);
  // R8
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> cpu_rdata == mem_rdata);
  // R6
  en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_en |=> win_en);
  // R7
  win_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_en |=> ($stable(win_first) && $stable(win_last)));
  // R9
  trap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_seen |=> trap_seen);
  // R10
  led_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_seen |-> !led_red);
endmodule

bind fetch_guard fetch_guard_chk #(.AW(AW), .DW(DW), .FWRAM_BASE(FWRAM_BASE),
  .FWRAM_BYTES(FWRAM_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_instr(bus_instr),
  .bus_addr(bus_addr), .mem_rdata(mem_rdata), .cpu_rdata(cpu_rdata),
  .win_en(win_en), .win_first(win_first), .win_last(win_last),
  .trap_seen(trap_seen), .led_red(led_red));

// File: tb/test_fetch_guard.sv
module test_fetch_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_instr = 1'b0, app_mode = 1'b0;
  logic [31:0] bus_addr = '0, mem_rdata = '0, cpu_rdata;
  logic [31:0] syscall_ptr = 32'h100, hash_ptr = 32'h200;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        cpu_trap = 1'b0, led_red;

  always #2 clk = ~clk;

  fetch_guard #(.BLINK_BITS(4)) i_fetch_guard (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_instr(bus_instr),
    .bus_addr(bus_addr), .mem_rdata(mem_rdata), .cpu_rdata(cpu_rdata),
    .app_mode(app_mode), .syscall_ptr(syscall_ptr), .hash_ptr(hash_ptr),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cpu_trap(cpu_trap), .led_red(led_red));

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sb_q[$];
  int n_cmp = 0, n_bad = 0;
  logic [31:0] tag = 32'hA500_0000;
  bit done = 0;

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      act = (it.kind == 0) ? cpu_rdata : (it.kind == 1) ? reg_rdata : {31'b0, led_red};
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
      end
    end
  end

  task automatic push(int kind, logic [31:0] exp, string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic access(logic instr, logic [31:0] addr, bit blocked, string req);
    @(posedge clk); #1;
    reg_we = 1'b0;
    tag = tag + 32'h11;
    bus_valid = 1'b1; bus_instr = instr; bus_addr = addr; mem_rdata = tag;
    push(0, blocked ? 32'h0 : tag, req);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1;
    bus_valid = 1'b0; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string req);
    @(posedge clk); #1;
    bus_valid = 1'b0; reg_we = 1'b0; reg_addr = a;
    push(1, exp, req);
  endtask

  task automatic led(bit trap, bit exp, string req);
    @(posedge clk); #1;
    bus_valid = 1'b0; reg_we = 1'b0; cpu_trap = trap;
    push(2, {31'b0, exp}, req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    rd(8'h60, 0, "R10 ctrl");
    rd(8'h61, 0, "R10 first");
    rd(8'h62, 0, "R10 last");
    led(0, 0, "R10 led");
    access(1, 32'h0000_0040, 0, "R3 fw-mode rom fetch");
    access(1, 32'hD000_0010, 1, "R1 fwram fetch fw mode");
    access(0, 32'hD000_0010, 0, "R1 fwram data read");
    access(0, 32'h4002_0000, 1, "R2 ram gap data");
    access(1, 32'h4002_0000, 1, "R2 ram gap fetch");
    access(0, 32'h4001_FFFC, 0, "R2 last physical word");
    access(1, 32'h4000_0000, 0, "R8 ram fetch");
    app_mode = 1'b1;
    access(1, 32'h0000_0040, 1, "R3 app rom fetch");
    access(0, 32'h0000_0040, 0, "R3 app rom data read");
    access(1, 32'hD000_0010, 1, "R1 fwram fetch app mode");
    access(1, 32'h0000_0100, 0, "R4 syscall entry");
    access(1, 32'h0000_0104, 0, "R4 rom open after entry");
    access(1, 32'h4000_0100, 0, "R8 return to ram");
    access(1, 32'h0000_0108, 1, "R4 rom closed after leaving");
    access(1, 32'h0000_0200, 0, "R4 hash entry");
    access(1, 32'h0000_0204, 0, "R4 rom open after hash entry");
    access(1, 32'h4000_0200, 0, "R8 ram fetch");
    access(1, 32'h4000_1000, 0, "R5 window not enabled");
    wr(8'h61, 32'h4000_1000);
    wr(8'h62, 32'h4000_10FC);
    rd(8'h61, 32'h4000_1000, "R6 first readback");
    rd(8'h62, 32'h4000_10FC, "R6 last readback");
    access(1, 32'h4000_1000, 0, "R5 still disabled");
    wr(8'h60, 32'h1);
    rd(8'h60, 32'h1, "R6 enable set");
    access(1, 32'h4000_1000, 1, "R5 first edge");
    access(1, 32'h4000_10FC, 1, "R5 last edge");
    access(1, 32'h4000_0FFC, 0, "R5 below window");
    access(1, 32'h4000_1100, 0, "R5 above window");
    access(0, 32'h4000_1080, 0, "R5 data read in window");
    wr(8'h61, 32'h4000_2000);
    wr(8'h62, 32'h4000_3000);
    rd(8'h61, 32'h4000_1000, "R7 first locked");
    rd(8'h62, 32'h4000_10FC, "R7 last locked");
    wr(8'h60, 32'h0);
    rd(8'h60, 32'h1, "R6 enable not cleared");
    access(1, 32'h4000_1040, 1, "R6 window still blocks");
    access(1, 32'h4000_2000, 0, "R7 rewritten range not used");
    led(1, 0, "R9 trap sampled, led not yet on");
    for (int j = 0; j < 20; j++) led(0, (j % 16) < 8, "R9 blink");
    @(posedge clk); #1 bus_valid = 1'b0;
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #40000;
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule